// File: doc/BRIEF.md
# Prioritised Two-Output Interrupt Controller (32 lines)

This block gathers 32 active-low interrupt request pins and presents them to a processor as two request outputs, a normal one (irq) and a fast one (fiq). Each line has its own configuration word. The word selects falling-edge or low-level capture, picks which of the two outputs the line feeds, and sets a 5-bit priority. Software works through a simple strobe-based register port that is one word wide. Through this port it masks lines, clears or forces pending bits, and reads the winning line number for each output.

Each output follows an arm / raise / acknowledge cycle. While an output is armed, the first cycle in which it has an eligible candidate raises the request and freezes the winning line number. The request then stays high until software writes the matching acknowledge bit in the control word, which drops the request and re-arms the output. Reading a winner index also retires an edge-captured pending bit. A level line stays pending for as long as its pin is held low.

Top module: `intc_legacy32`

## Requirements
- R1: After reset the mask word (offset 0x00 is pending, 0x04 is mask) reads 0xFFFFFFFF. The pending word, every configuration word and both winner indices read 0, and irq_req and fiq_req are low.
- R2: The configuration word of line n sits at offset 0x1C + 4*n and reads back only its low 7 bits: bits [6:2] priority, bit 1 capture type (1 = low level, 0 = falling edge), bit 0 output select (1 = fiq, 0 = irq). The mask word is read/write, with bit n = 1 meaning line n is masked.
- R3: An edge line becomes pending only on a high-to-low transition of its pin. It stays pending after the pin returns high. Clearing it while the pin stays low does not re-pend it.
- R4: A level line is pending while its pin is low, and its pending bit clears when the pin returns high.
- R5: A write to the pending word ANDs it with the written value, except that the bits of level lines whose pin is currently low stay set.
- R6: Among pending, unmasked lines that feed an output, the line with the numerically lowest priority wins. On equal priority, the higher line number wins.
- R7: A request rises one cycle after an armed output gains a candidate, latching the winner. It stays high with the index frozen until a write to the control word at 0x18 with bit 0 (irq) or bit 1 (fiq) drops it and re-arms that output only. The control word reads 0.
- R8: A read of 0x10 (irq) or 0x14 (fiq) returns the latched winner. If that line is edge-captured, the read clears its pending bit; a level line's pending bit is kept.
- R9: A write to 0x9C pends only the lowest set bit of the written value. The word reads 0.
- R10: Masked pending lines never raise a request. Writing the mask so that a pending line becomes unmasked raises the request of an armed output one cycle later.
- R11: Reads of unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_n | input | 32 | Interrupt request pins, active low, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on bus_rdata the following cycle |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Normal interrupt request, registered |
| fiq_req | output | 1 | Fast interrupt request, registered |

## Verification
Arbitration is exercised with two equal-priority lines pended together, which shows whether ties resolve toward the higher line number. It is also exercised with a low-numbered urgent line against a high-numbered lax one, which separates priority order from index order. Edge lines are pulsed, held low across a pending clear, and released to separate transition capture from level capture. A level line is held low across a pending clear and a winner read to confirm both leave it set. The acknowledge path is run on one output while the other is raised, to show the two are independent. Software triggers with several bits set, masked-then-unmasked pending lines and unmapped offsets cover the remaining paths.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Register offsets (byte addresses)
  localparam int OFS_PEND    = 'h00;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_SRC_IRQ = 'h10;
  localparam int OFS_SRC_FIQ = 'h14;
  localparam int OFS_CTRL    = 'h18;
  localparam int OFS_CFG0    = 'h1C;
  localparam int OFS_TRIG    = 'h9C;

  localparam int PRIO_W = 5;

  // Per-line configuration word, packed to match bits [6:2],[1],[0]
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              to_fiq;
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] src_n,
  input  logic [NLINES-1:0] lvl_i,
  input  logic              wr_and,
  input  logic [NLINES-1:0] and_val,
  input  logic [NLINES-1:0] rd_clr,
  input  logic [NLINES-1:0] sw_set,
  output logic [NLINES-1:0] pend_o
);
  logic [NLINES-1:0] asrt, prev_q, pend_q, keep, pend_nx;

  assign asrt = ~src_n;

  always_comb begin
    keep = pend_q;
    if (wr_and) keep = keep & (and_val | (asrt & lvl_i));
    keep = keep & ~rd_clr;
    keep = keep & ~(prev_q & ~asrt & lvl_i);
    pend_nx = keep | (asrt & ~prev_q & ~lvl_i) | (asrt & lvl_i) | sw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= asrt;
      pend_q <= pend_nx;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    // R3
    edge_new_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(pend_q[i]) && pend_q[i] && !$past(lvl_i[i])) |->
        (($past(asrt[i]) && !$past(prev_q[i])) || $past(sw_set[i])));
    // R4
    level_release_chk: assert property (@(posedge clk) disable iff (rst)
      $past(lvl_i[i] && prev_q[i] && !asrt[i] && !sw_set[i]) |-> !pend_q[i]);
    // R5
    level_keep_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr_and && lvl_i[i] && asrt[i]) |-> pend_q[i]);
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NLINES = 32,
  parameter int PW     = 5,
  parameter int IW     = $clog2(NLINES)
) (
  input  logic [NLINES-1:0]         act,
  input  logic [NLINES-1:0][PW-1:0] prio,
  output logic                      any_o,
  output logic [IW-1:0]             win_o
);
  logic [PW-1:0] best;

  always_comb begin
    best  = '1;
    any_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < NLINES; i++) begin
      // later (higher) index wins ties through <=
      if (act[i] && (!any_o || prio[i] <= best)) begin
        best  = prio[i];
        win_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_agree.sv
module intc_agree #(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_i,
  input  logic [IW-1:0] win_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [IW-1:0] sir_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      req_o   <= 1'b0;
      sir_o   <= '0;
    end else if (ack_i) begin
      req_o   <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && any_i) begin
      req_o   <= 1'b1;
      armed_q <= 1'b0;
      sir_o   <= win_i;
    end
  end

  // R7
  drop_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> $past(ack_i));
  // R7
  rise_has_cand_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(any_i));
  // R7
  index_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && $past(req_o)) |-> $stable(sir_o));
endmodule

// File: rtl/intc_legacy32.sv
module intc_legacy32
  import intc_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] src_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int IW       = $clog2(NLINES);
  localparam int CFG_LAST = OFS_CFG0 + 4 * (NLINES - 1);

  line_cfg_t         cfg_q [NLINES];
  logic [NLINES-1:0] mask_q, pend, lvl_vec, fiq_vec;
  logic [NLINES-1:0][PRIO_W-1:0] prio_arr;

  for (genvar i = 0; i < NLINES; i++) begin : g_cfg
    assign lvl_vec[i]  = cfg_q[i].level;
    assign fiq_vec[i]  = cfg_q[i].to_fiq;
    assign prio_arr[i] = cfg_q[i].prio;
  end

  // Address decode
  logic hit_pend, hit_mask, hit_sirq, hit_sfiq, hit_ctrl, hit_trig, hit_cfg, hit_any;
  logic [ADDR_W-1:0] cfg_off;
  logic [IW-1:0]     cfg_idx;

  assign hit_pend = (bus_addr == ADDR_W'(OFS_PEND));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_sirq = (bus_addr == ADDR_W'(OFS_SRC_IRQ));
  assign hit_sfiq = (bus_addr == ADDR_W'(OFS_SRC_FIQ));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_trig = (bus_addr == ADDR_W'(OFS_TRIG));
  assign hit_cfg  = (bus_addr[1:0] == 2'b00) &&
                    (bus_addr >= ADDR_W'(OFS_CFG0)) &&
                    (bus_addr <= ADDR_W'(CFG_LAST));
  assign hit_any  = hit_pend | hit_mask | hit_sirq | hit_sfiq |
                    hit_ctrl | hit_trig | hit_cfg;
  assign cfg_off  = bus_addr - ADDR_W'(OFS_CFG0);
  assign cfg_idx  = cfg_off[IW+1:2];

  // Mask and configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      for (int i = 0; i < NLINES; i++) cfg_q[i] <= '0;
    end else if (bus_wr) begin
      if (hit_mask) mask_q <= bus_wdata;
      if (hit_cfg)  cfg_q[cfg_idx] <= line_cfg_t'(bus_wdata[CFG_W-1:0]);
    end
  end

  // Two output channels: 0 = irq, 1 = fiq
  logic              any_c [2];
  logic [IW-1:0]     win_c [2];
  logic              req_c [2];
  logic [IW-1:0]     sir_c [2];
  logic [NLINES-1:0] clr_c [2];
  logic              hit_src [2];

  assign hit_src[0] = hit_sirq;
  assign hit_src[1] = hit_sfiq;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [NLINES-1:0] act;
    assign act = pend & ~mask_q & ((c == 1) ? fiq_vec : ~fiq_vec);

    intc_pick #(.NLINES(NLINES), .PW(PRIO_W), .IW(IW)) u_pick (
      .act  (act),
      .prio (prio_arr),
      .any_o(any_c[c]),
      .win_o(win_c[c])
    );

    intc_agree #(.IW(IW)) u_agree (
      .clk  (clk),
      .rst  (rst),
      .any_i(any_c[c]),
      .win_i(win_c[c]),
      .ack_i(bus_wr && hit_ctrl && bus_wdata[c]),
      .req_o(req_c[c]),
      .sir_o(sir_c[c])
    );

    // winner-index read retires an edge line only
    assign clr_c[c] = (bus_rd && hit_src[c]) ?
                      ((NLINES'(1) << sir_c[c]) & ~lvl_vec) : '0;
  end

  assign irq_req = req_c[0];
  assign fiq_req = req_c[1];

  // Pending capture
  logic [NLINES-1:0] sw_set;
  assign sw_set = (bus_wr && hit_trig) ? (bus_wdata & (~bus_wdata + NLINES'(1))) : '0;

  intc_capture #(.NLINES(NLINES)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .src_n  (src_n),
    .lvl_i  (lvl_vec),
    .wr_and (bus_wr && hit_pend),
    .and_val(bus_wdata),
    .rd_clr (clr_c[0] | clr_c[1]),
    .sw_set (sw_set),
    .pend_o (pend)
  );

  // Registered read path
  logic [NLINES-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_pend)      rd_val = pend;
    else if (hit_mask) rd_val = mask_q;
    else if (hit_sirq) rd_val = {{(NLINES-IW){1'b0}}, sir_c[0]};
    else if (hit_sfiq) rd_val = {{(NLINES-IW){1'b0}}, sir_c[1]};
    else if (hit_cfg)  rd_val = {{(NLINES-CFG_W){1'b0}}, cfg_q[cfg_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R1
  mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && !irq_req && !fiq_req));
  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && !hit_any) |-> $stable(mask_q));
  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past((pend & ~mask_q & ~fiq_vec) != '0));
endmodule

// File: tb/sim_intc_legacy32.sv
module sim_intc_legacy32;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_n = '1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req, fiq_req;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_legacy32 u0 (
    .clk(clk), .rst(rst), .src_n(src_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic judge(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) judge(bus_rdata, 32'hDEAD_BEEF, "queue underflow");
      else judge(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk);
    src_n[n] = v;
  endtask

  task automatic pins(input logic ei, input logic ef, input string tag);
    judge({30'b0, fiq_req, irq_req}, {30'b0, ef, ei}, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h04, 32'hFFFF_FFFF, "R1 mask");
    rd(8'h00, 32'h0, "R1 pending");
    rd(8'h30, 32'h0, "R1 cfg line5");
    rd(8'h10, 32'h0, "R1 irq index");
    pins(1'b0, 1'b0, "R1 outputs");

    // R2 config layout: line3 level, prio 9; upper bits dropped
    wr(8'h28, 32'hFFFF_FF26);
    rd(8'h28, 32'h26, "R2 cfg line3");

    // R3 edge capture on line4
    pin(4, 1'b0); idle(2);
    rd(8'h00, 32'h10, "R3 edge pends");
    wr(8'h00, 32'h0); idle(1);
    rd(8'h00, 32'h0, "R3 held low no repend");
    pin(4, 1'b1); idle(2);
    pin(4, 1'b0); idle(2);
    pin(4, 1'b1); idle(2);
    rd(8'h00, 32'h10, "R3 stays after release");
    wr(8'h00, 32'h0);

    // R4/R5 level line3
    pin(3, 1'b0); idle(2);
    rd(8'h00, 32'h08, "R4 level pends");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h08, "R5 asserted level kept");
    pin(3, 1'b1); idle(2);
    rd(8'h00, 32'h0, "R4 released clears");

    // R6 tie: lines 4 and 7 at prio 0, then unmask (R10)
    src_n[4] = 1'b0; src_n[7] = 1'b0; idle(2);
    src_n[4] = 1'b1; src_n[7] = 1'b1; idle(1);
    pins(1'b0, 1'b0, "R10 masked quiet");
    wr(8'h04, 32'hFFFF_FF6F); idle(1);
    pins(1'b1, 1'b0, "R10 unmask raises");
    rd(8'h04, 32'hFFFF_FF6F, "R2 mask readback");
    rd(8'h10, 32'd7, "R6 tie higher index");
    rd(8'h00, 32'h10, "R8 edge cleared by read");
    pins(1'b1, 1'b0, "R7 held until ack");
    wr(8'h18, 32'h1);
    pins(1'b0, 1'b0, "R7 ack drops");
    idle(1);
    pins(1'b1, 1'b0, "R7 rearm raises");
    rd(8'h10, 32'd4, "R7 next winner");
    wr(8'h18, 32'h1); idle(2);
    pins(1'b0, 1'b0, "R7 no candidates");

    // R6 priority beats index: line10 prio1, line12 prio5
    wr(8'h44, 32'h04);
    wr(8'h4C, 32'h14);
    wr(8'h04, 32'hFFFF_EB6F);
    src_n[10] = 1'b0; src_n[12] = 1'b0; idle(2);
    pins(1'b1, 1'b0, "R6 raise");
    rd(8'h10, 32'd10, "R6 lower prio value wins");
    src_n[10] = 1'b1; src_n[12] = 1'b1;
    wr(8'h18, 32'h1); idle(1);
    rd(8'h10, 32'd12, "R6 remaining line");
    wr(8'h18, 32'h1);
    rd(8'h00, 32'h0, "R8 both retired");

    // R8 level line not retired by index read
    wr(8'h04, 32'hFFFF_EB67);
    pin(3, 1'b0); idle(2);
    pins(1'b1, 1'b0, "R4 level raises");
    rd(8'h10, 32'd3, "R8 level index");
    rd(8'h00, 32'h08, "R8 level kept");
    pin(3, 1'b1); idle(2);
    rd(8'h00, 32'h0, "R4 level release");
    wr(8'h18, 32'h1); idle(2);
    pins(1'b0, 1'b0, "R7 idle after level");

    // R7 fiq channel independence, line20
    wr(8'h6C, 32'h01);
    wr(8'h04, 32'hFFEF_EB67);
    pin(20, 1'b0); idle(2);
    pins(1'b0, 1'b1, "R7 fiq raise");
    rd(8'h14, 32'd20, "R8 fiq index");
    wr(8'h18, 32'h1);
    pins(1'b0, 1'b1, "R7 irq ack leaves fiq");
    wr(8'h18, 32'h2);
    pins(1'b0, 1'b0, "R7 fiq ack");
    pin(20, 1'b1);
    rd(8'h18, 32'h0, "R7 control reads 0");
    rd(8'h00, 32'h0, "R8 fiq retired");

    // R9 software trigger, lowest bit only
    wr(8'h9C, 32'h1200_0000);
    rd(8'h00, 32'h0200_0000, "R9 lowest bit only");
    rd(8'h9C, 32'h0, "R9 reads 0");
    pins(1'b0, 1'b0, "R10 masked trigger quiet");
    wr(8'h04, 32'hFDEF_EB67); idle(1);
    pins(1'b1, 1'b0, "R10 unmask trigger");
    rd(8'h10, 32'd25, "R9 triggered index");
    wr(8'h18, 32'h1);
    rd(8'h00, 32'h0, "R9 retired");

    // R11 unmapped offsets
    rd(8'h08, 32'h0, "R11 read 0x08");
    wr(8'h0C, 32'h0);
    rd(8'h04, 32'hFDEF_EB67, "R11 mask untouched");
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0, "R11 cfg line0 untouched");
    rd(8'hA0, 32'h0, "R11 read 0xA0");
    pins(1'b0, 1'b0, "R11 outputs quiet");

    idle(2);
    if (exp_q.size() != 0) judge(32'(exp_q.size()), 32'h0, "scoreboard drained");
    summary();
    $finish;
  end
endmodule